// File: doc/BRIEF.md
# Configurable depth pixel formatter with palette

This block turns frame-buffer words into a stream of 24-bit RGB pixels. A 32-bit word arrives with a valid strobe and is split into one or more pixels, least significant end first, according to the pixel depth held in a control register. Indexed depths (1, 2, 4 and 8 bits) look each pixel up in a 256-entry colour table. Direct depths (15, 16 and 32 bits) unpack the colour channels straight from the word.

Software programs the block through a write-only register port. A byte address is turned into a register index by shifting it right by 2 or by 3. The shift is picked by a bit in register 0. Colour table entries sit at indices 0x100 to 0x1FF, and the control word sits at index 0x060. The display fetch reads memory in reverse bit order, so the block stores each table entry at the bit-reversed offset.

An internal state machine has two states. In `ST_IDLE` no word is in hand. In `ST_EMIT` the block puts out one pixel of the held word per cycle. The transitions are:
- LOAD (`ST_IDLE` to `ST_EMIT`): a valid word arrives.
- NEXT (`ST_EMIT` to `ST_EMIT`): pixels remain in the held word.
- CHAIN (`ST_EMIT` to `ST_EMIT`): a new word arrives during the last pixel of the current word.
- DRAIN (`ST_EMIT` to `ST_IDLE`): the last pixel goes out and no word arrives.

Top module: `pixfmt_top`

## Requirements
- R1: After reset, `px_valid` is 0, the address shift is 2, the colour table holds zeros, and the control word is 0, which blanks the output.
- R2: Control bits 22:20 select the depth: 0 is 1 bpp, 1 is 2 bpp, 2 is 4 bpp, 3 is 8 bpp, 4 is 15 bpp, 5 is 16 bpp, 6 is 32 bpp and 7 is blank. These give 32, 16, 8, 4, 2, 2, 1 and 1 pixels per word. Pixels are taken from bit 0 upward, and an indexed pixel's value selects that table slot.
- R3: A write to index 0x100+k stores red from data bits 7:0, green from 15:8 and blue from 23:16 into slot reverse(k), where bit 0 of k becomes bit 7. `px_rgb` carries red in 23:16, green in 15:8 and blue in 7:0.
- R4: At 15 bpp each 16-bit half holds blue in 4:0, green in 9:5 and red in 14:10, and bit 15 is ignored. Each 5-bit channel x becomes {x, x[4:2]}.
- R5: At 16 bpp each half holds blue in 4:0, green in 10:5 and red in 15:11. A 6-bit channel y becomes {y, y[5:4]}, and 5-bit channels expand as in R4.
- R6: At 32 bpp bits 7:0 go to blue, bits 15:8 to green and bits 23:16 to red. Bits 31:24 are ignored.
- R7: When control bit 0 is 0, or the depth is 7, the pixels are still produced with valid high, but `px_rgb` is 0.
- R8: The register index is the byte address shifted right by 3 when register 0 bit 6 is 1, and by 2 otherwise. Only the low 10 bits of the index are used. A write to register 0 changes the shift from the next write on.
- R9: The first pixel of a word accepted at clock edge n is output after edge n+2. The following pixels come on consecutive edges, and one word per cycle at 32 bpp gives a gap-free stream.
- R10: A word is accepted only when the block is idle or is on the last pixel of the current word. A `fb_valid` at any other time is dropped and produces no pixels.
- R11: The depth and blanking are sampled when a word is accepted. A control write in the same cycle as an acceptance takes effect from the next word on.
- R12: A colour table write in the same cycle as a lookup of that slot leaves that pixel with the old colour. Later pixels get the new colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | ADDR_W | Register byte address |
| cfg_wr_data | input | 32 | Register write data |
| fb_valid | input | 1 | Frame word valid |
| fb_word | input | 32 | Frame-buffer word |
| px_valid | output | 1 | Output pixel valid |
| px_rgb | output | 24 | Output pixel, red 23:16, green 15:8, blue 7:0 |

## Verification
Two events can fall in the same cycle and collide. The first is a control write arriving in the cycle a word is accepted. The second is a colour-table write arriving in the cycle the output stage looks up that same slot. The bench provokes both on purpose. It places a depth-changing control write on the same edge as a word, and it times a table write to land on the edge where a given pixel is registered. The cycle model judges each outcome: the accepted word keeps the old depth, the next word uses the new one, the colliding pixel shows the old colour, and a later pixel with the same index shows the new colour. Words offered while the block is busy are also driven, and the model expects them to vanish.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;

    localparam int WORD_W = 32;
    localparam int RGB_W  = 24;
    localparam int CNT_W  = $clog2(WORD_W) + 1;

    typedef enum logic [2:0] {
        DEP_1   = 3'd0,
        DEP_2   = 3'd1,
        DEP_4   = 3'd2,
        DEP_8   = 3'd3,
        DEP_15  = 3'd4,
        DEP_16  = 3'd5,
        DEP_32  = 3'd6,
        DEP_OFF = 3'd7
    } depth_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } unpk_state_e;

    // bits occupied by one pixel inside a word
    function automatic logic [CNT_W-1:0] slot_width(depth_e d);
        unique case (d)
            DEP_1:          return CNT_W'(1);
            DEP_2:          return CNT_W'(2);
            DEP_4:          return CNT_W'(4);
            DEP_8:          return CNT_W'(8);
            DEP_15, DEP_16: return CNT_W'(16);
            default:        return CNT_W'(32);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] pixels_per_word(depth_e d);
        return CNT_W'(WORD_W / int'(slot_width(d)));
    endfunction

    function automatic logic [WORD_W-1:0] code_mask(depth_e d);
        unique case (d)
            DEP_1:   return 32'h0000_0001;
            DEP_2:   return 32'h0000_0003;
            DEP_4:   return 32'h0000_000F;
            DEP_8:   return 32'h0000_00FF;
            DEP_15:  return 32'h0000_7FFF;
            DEP_16:  return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [7:0] widen5(logic [4:0] x);
        return {x, x[4:2]};
    endfunction

    function automatic logic [7:0] widen6(logic [5:0] y);
        return {y, y[5:4]};
    endfunction

endpackage

// File: rtl/pixfmt_regs.sv
module pixfmt_regs
    import pixfmt_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int IDX_W    = 10,
    parameter int CTRL_IDX = 'h060,
    parameter int PAL_BASE = 'h100,
    parameter int PAL_AW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output depth_e            ctrl_depth,
    output logic              ctrl_blank,
    output logic              align_wide,
    output logic              pal_we,
    output logic [PAL_AW-1:0] pal_slot,
    output logic [RGB_W-1:0]  pal_wdata
);

    localparam int PAL_HI = PAL_BASE >> PAL_AW;

    logic              wide_q;
    logic              en_q;
    depth_e            depth_q;
    logic [ADDR_W-1:0] shifted;
    logic [IDX_W-1:0]  idx;
    logic [PAL_AW-1:0] offs;
    logic              unused_bits;

    assign shifted = wide_q ? (wr_addr >> 3) : (wr_addr >> 2);
    assign idx     = shifted[IDX_W-1:0];
    assign offs    = idx[PAL_AW-1:0];
    assign unused_bits = ^{shifted, wr_data[31:24]};

    // slot is the offset with its bit order reversed
    for (genvar b = 0; b < PAL_AW; b++) begin : g_rev
        assign pal_slot[b] = offs[PAL_AW-1-b];
    end

    assign pal_we     = wr_en && (int'(idx >> PAL_AW) == PAL_HI);
    assign pal_wdata  = {wr_data[7:0], wr_data[15:8], wr_data[23:16]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_q  <= 1'b0;
            en_q    <= 1'b0;
            depth_q <= DEP_1;
        end else if (wr_en) begin
            if (idx == '0) begin
                wide_q <= wr_data[6];
            end
            if (int'(idx) == CTRL_IDX) begin
                en_q    <= wr_data[0];
                depth_q <= depth_e'(wr_data[22:20]);
            end
        end
    end

    assign ctrl_depth = depth_q;
    assign ctrl_blank = !en_q || (depth_q == DEP_OFF);
    assign align_wide = wide_q;

endmodule

// File: rtl/pixfmt_palette.sv
module pixfmt_palette #(
    parameter int AW = 8,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int ENTRIES = 1 << AW;

    logic [DW-1:0] mem [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pixfmt_unpack.sv
module pixfmt_unpack
    import pixfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  depth_e            ctrl_depth,
    input  logic              ctrl_blank,
    output logic              accept,
    output logic              emitting,
    output logic [CNT_W-1:0]  remain,
    output logic [WORD_W-1:0] pix_code,
    output depth_e            pix_depth,
    output logic              pix_blank
);

    unpk_state_e       state_q, state_d;
    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    depth_e            depth_q;
    logic              blank_q;
    logic              last;

    assign last   = (state_q == ST_EMIT) && (cnt_q == CNT_W'(1));
    assign accept = word_valid && ((state_q == ST_IDLE) || last);

    // next-state: LOAD, NEXT, CHAIN, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_EMIT;
            ST_EMIT: if (last && !accept) state_d = ST_IDLE;
        endcase
    end

    // state register and word data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
            cnt_q   <= '0;
            depth_q <= DEP_1;
            blank_q <= 1'b1;
        end else begin
            state_q <= state_d;
            if (accept) begin
                shreg_q <= word_data;
                cnt_q   <= pixels_per_word(ctrl_depth);
                depth_q <= ctrl_depth;
                blank_q <= ctrl_blank;
            end else if (state_q == ST_EMIT) begin
                shreg_q <= shreg_q >> slot_width(depth_q);
                cnt_q   <= cnt_q - CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        emitting  = (state_q == ST_EMIT);
        remain    = cnt_q;
        pix_code  = shreg_q & code_mask(depth_q);
        pix_depth = depth_q;
        pix_blank = blank_q;
    end

endmodule

// File: rtl/pixfmt_colour.sv
module pixfmt_colour
    import pixfmt_pkg::*;
(
    input  logic [WORD_W-1:0] code,
    input  depth_e            depth,
    input  logic              blank,
    input  logic [RGB_W-1:0]  pal_rdata,
    output logic [RGB_W-1:0]  rgb
);

    logic unused_hi;
    assign unused_hi = ^code[31:24];

    always_comb begin
        unique case (depth)
            DEP_1, DEP_2, DEP_4, DEP_8:
                rgb = pal_rdata;
            DEP_15:
                rgb = {widen5(code[14:10]), widen5(code[9:5]), widen5(code[4:0])};
            DEP_16:
                rgb = {widen5(code[15:11]), widen6(code[10:5]), widen5(code[4:0])};
            DEP_32:
                rgb = {code[23:16], code[15:8], code[7:0]};
            default:
                rgb = '0;
        endcase
        if (blank) begin
            rgb = '0;
        end
    end

endmodule

// File: rtl/pixfmt_top.sv
module pixfmt_top
    import pixfmt_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int IDX_W    = 10,
    parameter int CTRL_IDX = 'h060,
    parameter int PAL_BASE = 'h100,
    parameter int PAL_AW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [ADDR_W-1:0] cfg_wr_addr,
    input  logic [31:0]       cfg_wr_data,
    input  logic              fb_valid,
    input  logic [31:0]       fb_word,
    output logic              px_valid,
    output logic [23:0]       px_rgb
);

    depth_e            ctrl_depth;
    logic              ctrl_blank;
    logic              align_wide;
    logic              pal_we;
    logic [PAL_AW-1:0] pal_slot;
    logic [RGB_W-1:0]  pal_wdata;
    logic [RGB_W-1:0]  pal_rdata;
    logic              accept;
    logic              emitting;
    logic [CNT_W-1:0]  remain;
    logic [WORD_W-1:0] pix_code;
    depth_e            pix_depth;
    logic              pix_blank;
    logic [RGB_W-1:0]  rgb_d;

    pixfmt_regs #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX),
        .PAL_BASE(PAL_BASE), .PAL_AW(PAL_AW)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
        .ctrl_depth(ctrl_depth), .ctrl_blank(ctrl_blank), .align_wide(align_wide),
        .pal_we(pal_we), .pal_slot(pal_slot), .pal_wdata(pal_wdata)
    );

    pixfmt_palette #(.AW(PAL_AW), .DW(RGB_W)) pal_i (
        .clk(clk), .rst_n(rst_n),
        .we(pal_we), .waddr(pal_slot), .wdata(pal_wdata),
        .raddr(pix_code[PAL_AW-1:0]), .rdata(pal_rdata)
    );

    pixfmt_unpack unpk_i (
        .clk(clk), .rst_n(rst_n),
        .word_valid(fb_valid), .word_data(fb_word),
        .ctrl_depth(ctrl_depth), .ctrl_blank(ctrl_blank),
        .accept(accept), .emitting(emitting), .remain(remain),
        .pix_code(pix_code), .pix_depth(pix_depth), .pix_blank(pix_blank)
    );

    pixfmt_colour col_i (
        .code(pix_code), .depth(pix_depth), .blank(pix_blank),
        .pal_rdata(pal_rdata), .rgb(rgb_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            px_valid <= 1'b0;
            px_rgb   <= '0;
        end else begin
            px_valid <= emitting;
            px_rgb   <= emitting ? rgb_d : '0;
        end
    end

endmodule

// File: rtl/pixfmt_chk.sv
module pixfmt_chk #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 10,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [ADDR_W-1:0] cfg_wr_addr,
    input logic [31:0]       cfg_wr_data,
    input logic              accept,
    input logic              emitting,
    input logic [CNT_W-1:0]  remain,
    input logic              ctrl_blank,
    input logic              align_wide,
    input logic              px_valid,
    input logic [23:0]       px_rgb
);

    logic [ADDR_W-1:0] sh_addr;
    logic              hits_reg0;
    assign sh_addr   = align_wide ? (cfg_wr_addr >> 3) : (cfg_wr_addr >> 2);
    assign hits_reg0 = cfg_wr_en && (sh_addr[IDX_W-1:0] == '0);

    assert_first_pixel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##2 px_valid);

    assert_quiet_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !emitting |=> !px_valid);

    assert_blank_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ctrl_blank) |-> ##2 (px_rgb == 24'd0));

    assert_align_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hits_reg0 |=> (align_wide == $past(cfg_wr_data[6])));

    assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        emitting |-> (remain != '0 && remain <= CNT_W'(32)));

endmodule

bind pixfmt_top pixfmt_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(pixfmt_pkg::CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
    .accept(accept), .emitting(emitting), .remain(remain),
    .ctrl_blank(ctrl_blank), .align_wide(align_wide),
    .px_valid(px_valid), .px_rgb(px_rgb)
);

// File: tb/pixfmt_top_tb_top.sv
module pixfmt_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        fb_valid = 1'b0;
    logic [31:0] fb_word = '0;
    logic        px_valid;
    logic [23:0] px_rgb;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #5 clk = ~clk;

    pixfmt_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
        .fb_valid(fb_valid), .fb_word(fb_word),
        .px_valid(px_valid), .px_rgb(px_rgb)
    );

    // ---------------- behavioural reference model ----------------
    logic [23:0] m_pal [256];
    int          m_shift;
    logic [31:0] m_ctrl;
    int          m_cyc;
    int          m_free;
    int          q_due [$];
    logic [31:0] q_code [$];
    int          q_dep [$];
    bit          q_blk [$];
    bit          exp_v;
    logic [23:0] exp_rgb;

    function automatic int rev8(int v);
        int r = 0;
        for (int b = 0; b < 8; b++) if (v[b]) r |= (1 << (7 - b));
        return r;
    endfunction

    function automatic int e5(int x);
        return ((x << 3) | (x >> 2)) & 255;
    endfunction

    function automatic int e6(int y);
        return ((y << 2) | (y >> 4)) & 255;
    endfunction

    function automatic logic [23:0] ref_colour(logic [31:0] c, int dep, bit blk);
        int r, g, b;
        if (blk) return 24'd0;
        case (dep)
            0, 1, 2, 3: return m_pal[c & 255];
            4: begin r = e5((c >> 10) & 31); g = e5((c >> 5) & 31); b = e5(c & 31); end
            5: begin r = e5((c >> 11) & 31); g = e6((c >> 5) & 63); b = e5(c & 31); end
            6: begin r = (c >> 16) & 255; g = (c >> 8) & 255; b = c & 255; end
            default: return 24'd0;
        endcase
        return 24'((r << 16) | (g << 8) | b);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) m_pal[i] = '0;
            m_shift = 2; m_ctrl = '0; m_cyc = 0; m_free = 0;
            q_due.delete(); q_code.delete(); q_dep.delete(); q_blk.delete();
            exp_v = 1'b0; exp_rgb = '0;
        end else begin
            exp_v = 1'b0; exp_rgb = '0;
            if (q_due.size() > 0 && q_due[0] == m_cyc) begin
                exp_v   = 1'b1;
                exp_rgb = ref_colour(q_code[0], q_dep[0], q_blk[0]);
                void'(q_due.pop_front()); void'(q_code.pop_front());
                void'(q_dep.pop_front()); void'(q_blk.pop_front());
            end
            if (fb_valid && m_cyc >= m_free) begin
                int dep, w, n;
                bit blk;
                longint msk;
                dep = int'(m_ctrl[22:20]);
                blk = !m_ctrl[0] || dep == 7;
                w   = (dep < 4) ? (1 << dep) : (dep < 6 ? 16 : 32);
                if (dep == 4) msk = 'h7FFF; else msk = (64'd1 << w) - 1;
                n   = 32 / w;
                for (int k = 0; k < n; k++) begin
                    q_due.push_back(m_cyc + 1 + k);
                    q_code.push_back(32'((longint'(fb_word) >> (k * w)) & msk));
                    q_dep.push_back(dep);
                    q_blk.push_back(blk);
                end
                m_free = m_cyc + n;
            end
            if (cfg_wr_en) begin
                int idx;
                idx = (int'(cfg_wr_addr) >> m_shift) & 'h3FF;
                if (idx == 0) m_shift = cfg_wr_data[6] ? 3 : 2;
                if (idx == 'h060) m_ctrl = cfg_wr_data;
                if (idx >= 'h100 && idx < 'h200)
                    m_pal[rev8(idx - 'h100)] = {cfg_wr_data[7:0], cfg_wr_data[15:8], cfg_wr_data[23:16]};
            end
            m_cyc++;
        end
    end

    // ---------------- comparison every clock ----------------
    always @(negedge clk) begin
        if (!done) begin
            n_cmp++;
            if (!rst_n) begin
                if (px_valid !== 1'b0) begin
                    n_bad++;
                    $display("FAIL R1 reset: px_valid=%b expected 0", px_valid);
                end
            end else if (px_valid !== exp_v || (exp_v && px_rgb !== exp_rgb)) begin
                n_bad++;
                $display("FAIL %s cycle %0d: valid=%b rgb=%06h expected valid=%b rgb=%06h",
                         cur_req, m_cyc, px_valid, px_rgb, exp_v, exp_rgb);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(bit we, logic [15:0] a, logic [31:0] d, bit v, logic [31:0] w);
        cfg_wr_en = we; cfg_wr_addr = a; cfg_wr_data = d;
        fb_valid = v; fb_word = w;
        @(negedge clk);
        cfg_wr_en = 1'b0; fb_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, '0, '0, 0, '0);
    endtask

    function automatic logic [31:0] ctl(int dep, bit en);
        return (32'(dep) << 20) | 32'(en);
    endfunction

    localparam logic [15:0] CTRL_A2 = 16'h0060 << 2;
    localparam logic [15:0] CTRL_A3 = 16'h0060 << 3;

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: default control is 0, so the depth-0 word yields 32 blank pixels
        cur_req = "R1";
        step(0, '0, '0, 1, 32'hFFFF_FFFF);
        idle(34);

        // R3: fill the colour table through the reversed-slot write path
        cur_req = "R3";
        for (int i = 0; i < 256; i++)
            step(1, 16'((16'h100 + i) << 2), 32'((i * 7 + 3) << 16 | ((255 - i) << 8) | (i ^ 8'h5A)), 0, '0);

        // R2: each indexed depth, LSB-first extraction
        cur_req = "R2";
        for (int dep = 0; dep < 4; dep++) begin
            step(1, CTRL_A2, ctl(dep, 1), 0, '0);
            step(0, '0, '0, 1, 32'hC3A5_1E96 ^ 32'(dep * 32'h1111_1111));
            idle(32 >> dep);
            step(0, '0, '0, 1, 32'h0F1E_2D3C);
            idle((32 >> dep) + 2);
        end

        // R10: valid held high while busy; only words at word boundaries count
        cur_req = "R10";
        step(1, CTRL_A2, ctl(3, 1), 0, '0);
        for (int i = 0; i < 10; i++) step(0, '0, '0, 1, 32'h1020_3040 + 32'(i * 32'h0101_0101));
        idle(6);

        // R4: 15-bit direct
        cur_req = "R4";
        step(1, CTRL_A2, ctl(4, 1), 0, '0);
        step(0, '0, '0, 1, 32'h7FFF_8000);
        step(0, '0, '0, 0, '0);
        step(0, '0, '0, 1, 32'h1234_C321);
        idle(4);

        // R5: 16-bit direct
        cur_req = "R5";
        step(1, CTRL_A2, ctl(5, 1), 0, '0);
        step(0, '0, '0, 1, 32'hF81F_07E0);
        step(0, '0, '0, 0, '0);
        step(0, '0, '0, 1, 32'h8421_FFFF);
        idle(4);

        // R6: 32-bit direct channel placement
        cur_req = "R6";
        step(1, CTRL_A2, ctl(6, 1), 0, '0);
        step(0, '0, '0, 1, 32'hAB11_2233);
        idle(3);

        // R9: one word per cycle gives a gap-free stream two edges later
        cur_req = "R9";
        for (int i = 0; i < 6; i++) step(0, '0, '0, 1, 32'h0055_AA00 + 32'(i * 32'h0003_0507));
        idle(4);

        // R11: control write and word acceptance in the same cycle
        cur_req = "R11";
        step(1, CTRL_A2, ctl(3, 1), 1, 32'h00C0_FFEE);
        step(0, '0, '0, 1, 32'h0403_0201);
        idle(6);

        // R12: table write lands on the edge its slot is looked up
        cur_req = "R12";
        step(0, '0, '0, 1, 32'h2C7F_2C01);
        step(0, '0, '0, 0, '0);
        step(1, 16'((16'h100 + rev8(8'h2C)) << 2), 32'h0077_8899, 0, '0);
        idle(5);

        // R7: blank by depth 7 and by enable low
        cur_req = "R7";
        step(1, CTRL_A2, ctl(7, 1), 0, '0);
        step(0, '0, '0, 1, 32'h00FF_FFFF);
        idle(3);
        step(1, CTRL_A2, ctl(6, 0), 0, '0);
        step(0, '0, '0, 1, 32'h0012_3456);
        idle(3);

        // R8: switch to the wide shift and use the new addressing
        cur_req = "R8";
        step(1, 16'h0000, 32'h0000_0040, 0, '0);
        step(1, CTRL_A3, ctl(6, 1), 0, '0);
        step(0, '0, '0, 1, 32'h0031_4159);
        idle(3);
        step(1, CTRL_A2, ctl(3, 1), 0, '0);
        step(0, '0, '0, 1, 32'h0026_5358);
        idle(3);
        step(1, 16'((16'h100 + rev8(8'h11)) << 3), 32'h00AB_CDEF, 0, '0);
        step(1, CTRL_A3, ctl(3, 1), 0, '0);
        step(0, '0, '0, 1, 32'h1111_1111);
        idle(6);
        step(1, 16'h0000, 32'h0000_0000, 0, '0);
        step(1, CTRL_A2, ctl(0, 1), 0, '0);
        step(0, '0, '0, 1, 32'h8000_0001);
        idle(36);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL R9 watchdog: run still active, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule